// File: doc/BRIEF.md
# Compact Instruction Word Decoder

This block turns a stream of 16-bit instruction words for a small 8-bit load/store microcontroller into a decoded record. The record holds an operation code and a set of operand fields: destination register, source register, I/O address, status bit number, 8-bit immediate, relative branch offset and a far address. A fetch unit presents one word per cycle on `word_in`, qualified by `word_valid`. The decoder answers with a one-cycle `done` strobe, and the record is valid in that same cycle. The record keeps its value until the next `done`.

Most opcodes fit in one word. Direct data loads and stores, and absolute jumps and calls, need a second word that carries a 16-bit address. A small state machine handles these. In state `ST_FIRST` it decodes each valid word. When the word opens a two-word opcode, it keeps the partial record and moves to `ST_SECOND` (transition FIRST→SECOND). The next valid word in `ST_SECOND` is taken as the address, whatever its bit pattern. That word completes the record, raises `done` and returns the machine to `ST_FIRST` (transition SECOND→FIRST). Cycles without `word_valid` leave both states unchanged. Reset forces `ST_FIRST`.

Operand fields that an opcode does not use read as zero. Words outside the decoded groups produce the illegal class.

Top module: `insn_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears `done`, clears the record to zero and drops any pending half of a two-word opcode, so the next valid word is decoded as a first word.
- R2: Words whose bits 15:10 are 000001..001011 decode in this order: 000001 CPC, 000010 SBC, 000011 ADD, 000100 CPSE, 000101 CP, 000110 SUB, 000111 ADC, 001000 AND, 001001 EOR, 001010 OR, 001011 MOV. For these, `rd_idx` = {w[8], w[7:4]} and `rr_idx` = {w[9], w[3:0]}.
- R3: Word 0000 0001 dddd rrrr decodes as MOVW, with `rd_idx` = 2·dddd and `rr_idx` = 2·rrrr. Both indices are always even.
- R4: Top nibbles 0011 CPI, 0100 SBCI, 0101 SUBI, 0110 ORI, 0111 ANDI and 1110 LDI decode with `rd_idx` = 16 + w[7:4] and `imm_val` = {w[11:8], w[3:0]}.
- R5: 1001 0110 KKdd KKKK decodes as ADIW and 1001 0111 KKdd KKKK as SBIW. For both, `rd_idx` = 24 + 2·dd and `imm_val` = {00, w[7:6], w[3:0]}.
- R6: 1001 010d dddd with low nibble 0000 COM, 0001 NEG, 0010 SWAP, 0011 INC, 0101 ASR, 0110 LSR, 0111 ROR or 1010 DEC decodes as that single-register operation, with `rd_idx` = w[8:4]. Low nibble 0100 is illegal.
- R7: 1011 0AAd dddd AAAA decodes as IN, with `rd_idx` = w[8:4]. 1011 1AAr rrrr AAAA decodes as OUT, with `rr_idx` = w[8:4]. For both, `io_addr` = {w[10:9], w[3:0]}.
- R8: 1001 0100 0sss 1000 decodes as BSET and 1001 0100 1sss 1000 as BCLR, with `bit_idx` = sss. The index order is C=0, Z, N, V, S, H, T, I=7.
- R9: 1001 000d dddd 0000 (LDS, register in `rd_idx`) and 1001 001r rrrr 0000 (STS, register in `rr_idx`) raise no `done` on their first word. The next valid word, after any number of idle cycles, becomes `far_addr[15:0]`, with `far_addr[21:16]` = 0.
- R10: 1001 010k kkkk 110k decodes as JMP and 1001 010k kkkk 111k as CALL. Both take a second word. `far_addr` = {w[8:4], w[0], second word}.
- R11: Top nibble 1100 decodes as RJMP and 1101 as RCALL, with `rel_ofs` = w[11:0].
- R12: The all-zero word decodes as NOP. Every other word outside R2–R11 decodes as ILLEGAL (code 0), and all of its operand fields are zero.
- R13: `done` goes high exactly one cycle after the clock edge that accepts a completing word, and stays high for one cycle only. Cycles with `word_valid` low produce no `done` and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | `word_in` carries a fetched word |
| word_in | input | 16 | Instruction or address word |
| done | output | 1 | One-cycle strobe: the record is complete |
| op_code | output | 6 | Operation class (package enum) |
| rd_idx | output | 5 | Destination register index |
| rr_idx | output | 5 | Source register index |
| io_addr | output | 6 | I/O space address |
| bit_idx | output | 3 | Status bit number |
| imm_val | output | 8 | Immediate constant |
| rel_ofs | output | 12 | Relative branch offset, two's complement |
| far_addr | output | 22 | Direct data address or absolute target |

## Verification
The hardest situations to reach are those where the machine sits in `ST_SECOND` and something unusual arrives. Three cases matter: a long run of idle cycles, a reset, or a second word whose bit pattern is itself a two-word opcode. Directed sequences build each case on purpose. They hold `word_valid` low for several cycles between the halves, pulse reset between them, and feed 0x9100 and 0x940C as address words. A long randomized run with sparse `word_valid` and occasional resets then mixes these cases with every decode group. Throughout, a behavioural model checks the outputs on every clock.

// File: rtl/insn_dec_pkg.sv
`timescale 1ns/1ps
package insn_dec_pkg;
    localparam int WORD_W   = 16;
    localparam int REG_W    = 5;
    localparam int IO_W     = 6;
    localparam int BIT_W    = 3;
    localparam int IMM_W    = 8;
    localparam int REL_W    = 12;
    localparam int FAR_W    = 22;
    localparam int OP_W     = 6;
    localparam int FAR_HI_W = FAR_W - WORD_W;

    typedef enum logic [OP_W-1:0] {
        OP_ILLEGAL = 6'd0,
        OP_NOP, OP_MOVW,
        OP_CPC, OP_SBC, OP_ADD, OP_CPSE, OP_CP, OP_SUB, OP_ADC,
        OP_AND, OP_EOR, OP_OR, OP_MOV,
        OP_CPI, OP_SBCI, OP_SUBI, OP_ORI, OP_ANDI, OP_LDI,
        OP_COM, OP_NEG, OP_SWAP, OP_INC, OP_ASR, OP_LSR, OP_ROR, OP_DEC,
        OP_ADIW, OP_SBIW, OP_IN, OP_OUT, OP_BSET, OP_BCLR,
        OP_LDS, OP_STS, OP_JMP, OP_CALL, OP_RJMP, OP_RCALL
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rr;
        logic [IO_W-1:0]   io;
        logic [BIT_W-1:0]  bitn;
        logic [IMM_W-1:0]  imm;
        logic [REL_W-1:0]  rel;
        logic [FAR_W-1:0]  far;
    } dec_rec_t;

    typedef enum logic {
        ST_FIRST  = 1'b0,
        ST_SECOND = 1'b1
    } cap_state_e;
endpackage

// File: rtl/insn_word_decode.sv
`timescale 1ns/1ps
module insn_word_decode
    import insn_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_rec_t          rec,
    output logic              needs_ext
);
    localparam logic [3:0] PAIR_BASE = 4'd12;

    function automatic op_e alu2_op(input logic [3:0] sel);
        unique case (sel)
            4'h1:    return OP_CPC;
            4'h2:    return OP_SBC;
            4'h3:    return OP_ADD;
            4'h4:    return OP_CPSE;
            4'h5:    return OP_CP;
            4'h6:    return OP_SUB;
            4'h7:    return OP_ADC;
            4'h8:    return OP_AND;
            4'h9:    return OP_EOR;
            4'hA:    return OP_OR;
            4'hB:    return OP_MOV;
            default: return OP_ILLEGAL;
        endcase
    endfunction

    function automatic op_e unary_op(input logic [3:0] low);
        unique case (low)
            4'h0:    return OP_COM;
            4'h1:    return OP_NEG;
            4'h2:    return OP_SWAP;
            4'h3:    return OP_INC;
            4'h5:    return OP_ASR;
            4'h6:    return OP_LSR;
            4'h7:    return OP_ROR;
            4'hA:    return OP_DEC;
            default: return OP_ILLEGAL;
        endcase
    endfunction

    op_e un_op;
    assign un_op = unary_op(word[3:0]);

    always_comb begin
        rec       = '0;
        rec.op    = OP_ILLEGAL;
        needs_ext = 1'b0;
        unique case (word[15:12])
            4'h0, 4'h1, 4'h2: begin
                if (word[13:10] == 4'h0) begin
                    if (word[11:0] == 12'h000) begin
                        rec.op = OP_NOP;
                    end else if (word[11:8] == 4'h1) begin
                        rec.op = OP_MOVW;
                        rec.rd = {word[7:4], 1'b0};
                        rec.rr = {word[3:0], 1'b0};
                    end
                end else begin
                    rec.op = alu2_op(word[13:10]);
                    if (rec.op != OP_ILLEGAL) begin
                        rec.rd = {word[8], word[7:4]};
                        rec.rr = {word[9], word[3:0]};
                    end
                end
            end
            4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE: begin
                unique case (word[15:12])
                    4'h3:    rec.op = OP_CPI;
                    4'h4:    rec.op = OP_SBCI;
                    4'h5:    rec.op = OP_SUBI;
                    4'h6:    rec.op = OP_ORI;
                    4'h7:    rec.op = OP_ANDI;
                    default: rec.op = OP_LDI;
                endcase
                rec.rd  = {1'b1, word[7:4]};
                rec.imm = {word[11:8], word[3:0]};
            end
            4'h9: begin
                unique case (word[11:9])
                    3'b000: if (word[3:0] == 4'h0) begin
                        rec.op    = OP_LDS;
                        rec.rd    = word[8:4];
                        needs_ext = 1'b1;
                    end
                    3'b001: if (word[3:0] == 4'h0) begin
                        rec.op    = OP_STS;
                        rec.rr    = word[8:4];
                        needs_ext = 1'b1;
                    end
                    3'b010: begin
                        if (word[3:1] == 3'b110 || word[3:1] == 3'b111) begin
                            rec.op    = word[1] ? OP_CALL : OP_JMP;
                            rec.far   = {word[8:4], word[0], {WORD_W{1'b0}}};
                            needs_ext = 1'b1;
                        end else if (word[3:0] == 4'h8) begin
                            if (!word[8]) begin
                                rec.op   = word[7] ? OP_BCLR : OP_BSET;
                                rec.bitn = word[6:4];
                            end
                        end else if (un_op != OP_ILLEGAL) begin
                            rec.op = un_op;
                            rec.rd = word[8:4];
                        end
                    end
                    3'b011: begin
                        rec.op  = word[8] ? OP_SBIW : OP_ADIW;
                        rec.rd  = {PAIR_BASE[3:2], word[5:4], 1'b0};
                        rec.imm = {2'b00, word[7:6], word[3:0]};
                    end
                    default: ;
                endcase
            end
            4'hB: begin
                rec.io = {word[10:9], word[3:0]};
                if (word[11]) begin
                    rec.op = OP_OUT;
                    rec.rr = word[8:4];
                end else begin
                    rec.op = OP_IN;
                    rec.rd = word[8:4];
                end
            end
            4'hC, 4'hD: begin
                rec.op  = word[12] ? OP_RCALL : OP_RJMP;
                rec.rel = word[11:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/insn_capture_fsm.sv
`timescale 1ns/1ps
module insn_capture_fsm
    import insn_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  dec_rec_t          dec,
    input  logic              needs_ext,
    output logic              done_q,
    output dec_rec_t          rec_q
);
    cap_state_e state, nxt;
    dec_rec_t   pend_q;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FIRST;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FIRST:  if (word_valid && needs_ext) nxt = ST_SECOND;
            ST_SECOND: if (word_valid)              nxt = ST_FIRST;
            default:   nxt = ST_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            rec_q  <= '0;
            pend_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (word_valid) begin
                unique case (state)
                    ST_FIRST: begin
                        if (needs_ext) begin
                            pend_q <= dec;
                        end else begin
                            rec_q  <= dec;
                            done_q <= 1'b1;
                        end
                    end
                    ST_SECOND: begin
                        rec_q     <= pend_q;
                        rec_q.far <= {pend_q.far[FAR_W-1:WORD_W], word_in};
                        done_q    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R13: a strobe always traces back to an accepted word
    a_r13_done_needs_valid: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(word_valid));
    // R9: waiting for the second word with no input produces nothing
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SECOND && !word_valid) |=> (!done_q && state == ST_SECOND));
    // R9: the second word always completes the record
    a_r9_second_completes: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SECOND && word_valid) |=> (done_q && state == ST_FIRST));
    // R3: register pairs are even
    a_r3_pair_even: assert property (@(posedge clk) disable iff (rst)
        (done_q && rec_q.op == OP_MOVW) |-> (!rec_q.rd[0] && !rec_q.rr[0]));
    // R4: immediate forms reach only the upper register half
    a_r4_upper_half: assert property (@(posedge clk) disable iff (rst)
        (done_q && (rec_q.op == OP_LDI || rec_q.op == OP_CPI || rec_q.op == OP_ANDI))
        |-> rec_q.rd[REG_W-1]);
    // R12: illegal words carry no operands
    a_r12_illegal_clear: assert property (@(posedge clk) disable iff (rst)
        (done_q && rec_q.op == OP_ILLEGAL)
        |-> (rec_q.rd == '0 && rec_q.rr == '0 && rec_q.imm == '0 && rec_q.far == '0));
endmodule

// File: rtl/insn_decoder.sv
`timescale 1ns/1ps
module insn_decoder
    import insn_dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                word_valid,
    input  logic [WORD_W-1:0]   word_in,
    output logic                done,
    output logic [OP_W-1:0]     op_code,
    output logic [REG_W-1:0]    rd_idx,
    output logic [REG_W-1:0]    rr_idx,
    output logic [IO_W-1:0]     io_addr,
    output logic [BIT_W-1:0]    bit_idx,
    output logic [IMM_W-1:0]    imm_val,
    output logic [REL_W-1:0]    rel_ofs,
    output logic [FAR_W-1:0]    far_addr
);
    dec_rec_t dec_w;
    dec_rec_t rec_q;
    logic     ext_w;

    insn_word_decode u_decode (
        .word      (word_in),
        .rec       (dec_w),
        .needs_ext (ext_w)
    );

    insn_capture_fsm u_capture (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word_in    (word_in),
        .dec        (dec_w),
        .needs_ext  (ext_w),
        .done_q     (done),
        .rec_q      (rec_q)
    );

    assign op_code  = rec_q.op;
    assign rd_idx   = rec_q.rd;
    assign rr_idx   = rec_q.rr;
    assign io_addr  = rec_q.io;
    assign bit_idx  = rec_q.bitn;
    assign imm_val  = rec_q.imm;
    assign rel_ofs  = rec_q.rel;
    assign far_addr = rec_q.far;
endmodule

// File: tb/test_insn_decoder.sv
`timescale 1ns/1ps
module test_insn_decoder;
    import insn_dec_pkg::*;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rd;
        logic [4:0]  rr;
        logic [5:0]  io;
        logic [2:0]  bn;
        logic [7:0]  imm;
        logic [11:0] rel;
        logic [21:0] far;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [15:0] wd  = 16'h0;
    logic        done;
    logic [5:0]  op_code;
    logic [4:0]  rd_idx, rr_idx;
    logic [5:0]  io_addr;
    logic [2:0]  bit_idx;
    logic [7:0]  imm_val;
    logic [11:0] rel_ofs;
    logic [21:0] far_addr;
    exp_t        got;

    insn_decoder i_insn_decoder (
        .clk(clk), .rst(rst), .word_valid(vld), .word_in(wd),
        .done(done), .op_code(op_code), .rd_idx(rd_idx), .rr_idx(rr_idx),
        .io_addr(io_addr), .bit_idx(bit_idx), .imm_val(imm_val),
        .rel_ofs(rel_ofs), .far_addr(far_addr)
    );

    assign got = {op_code, rd_idx, rr_idx, io_addr, bit_idx, imm_val, rel_ofs, far_addr};

    always #2.5 clk = ~clk;

    int   total = 0;
    int   bad   = 0;
    bit   finished = 0;
    bit   m_pend = 0;
    exp_t m_hold;
    bit   exp_done = 0;
    exp_t exp_rec;

    function automatic void ref_dec(input logic [15:0] w, output exp_t e, output bit two);
        e = '0; e.op = OP_ILLEGAL; two = 0;
        casez (w)
            16'h0000: e.op = OP_NOP;
            16'b0000_0001_????_????: begin
                e.op = OP_MOVW; e.rd = 5'(int'(w[7:4]) * 2); e.rr = 5'(int'(w[3:0]) * 2);
            end
            16'b0000_01??_????_????, 16'b0000_1???_????_????,
            16'b0001_????_????_????, 16'b0010_????_????_????: begin
                case (w[15:10])
                    6'b000001: e.op = OP_CPC;   6'b000010: e.op = OP_SBC;
                    6'b000011: e.op = OP_ADD;   6'b000100: e.op = OP_CPSE;
                    6'b000101: e.op = OP_CP;    6'b000110: e.op = OP_SUB;
                    6'b000111: e.op = OP_ADC;   6'b001000: e.op = OP_AND;
                    6'b001001: e.op = OP_EOR;   6'b001010: e.op = OP_OR;
                    6'b001011: e.op = OP_MOV;   default:   e.op = OP_ILLEGAL;
                endcase
                if (e.op != OP_ILLEGAL) begin
                    e.rd = 5'(int'(w[8]) * 16 + int'(w[7:4]));
                    e.rr = 5'(int'(w[9]) * 16 + int'(w[3:0]));
                end
            end
            16'b0011_????_????_????, 16'b0100_????_????_????, 16'b0101_????_????_????,
            16'b0110_????_????_????, 16'b0111_????_????_????, 16'b1110_????_????_????: begin
                case (w[15:12])
                    4'h3: e.op = OP_CPI;  4'h4: e.op = OP_SBCI; 4'h5: e.op = OP_SUBI;
                    4'h6: e.op = OP_ORI;  4'h7: e.op = OP_ANDI; default: e.op = OP_LDI;
                endcase
                e.rd  = 5'(16 + int'(w[7:4]));
                e.imm = 8'(int'(w[11:8]) * 16 + int'(w[3:0]));
            end
            16'b1001_000?_????_0000: begin e.op = OP_LDS; e.rd = w[8:4]; two = 1; end
            16'b1001_001?_????_0000: begin e.op = OP_STS; e.rr = w[8:4]; two = 1; end
            16'b1001_0100_0???_1000: begin e.op = OP_BSET; e.bn = w[6:4]; end
            16'b1001_0100_1???_1000: begin e.op = OP_BCLR; e.bn = w[6:4]; end
            16'b1001_010?_????_0???: begin
                case (w[2:0])
                    3'd0: e.op = OP_COM; 3'd1: e.op = OP_NEG; 3'd2: e.op = OP_SWAP;
                    3'd3: e.op = OP_INC; 3'd5: e.op = OP_ASR; 3'd6: e.op = OP_LSR;
                    3'd7: e.op = OP_ROR; default: e.op = OP_ILLEGAL;
                endcase
                if (e.op != OP_ILLEGAL) e.rd = w[8:4];
            end
            16'b1001_010?_????_1010: begin e.op = OP_DEC; e.rd = w[8:4]; end
            16'b1001_010?_????_110?: begin
                e.op = OP_JMP; e.far = 22'(int'(w[8:4]) * 2 + int'(w[0])) << 16; two = 1;
            end
            16'b1001_010?_????_111?: begin
                e.op = OP_CALL; e.far = 22'(int'(w[8:4]) * 2 + int'(w[0])) << 16; two = 1;
            end
            16'b1001_0110_????_????, 16'b1001_0111_????_????: begin
                e.op  = w[8] ? OP_SBIW : OP_ADIW;
                e.rd  = 5'(24 + 2 * int'(w[5:4]));
                e.imm = 8'(int'(w[7:6]) * 16 + int'(w[3:0]));
            end
            16'b1011_0???_????_????: begin
                e.op = OP_IN; e.rd = w[8:4]; e.io = 6'(int'(w[10:9]) * 16 + int'(w[3:0]));
            end
            16'b1011_1???_????_????: begin
                e.op = OP_OUT; e.rr = w[8:4]; e.io = 6'(int'(w[10:9]) * 16 + int'(w[3:0]));
            end
            16'b1100_????_????_????: begin e.op = OP_RJMP;  e.rel = w[11:0]; end
            16'b1101_????_????_????: begin e.op = OP_RCALL; e.rel = w[11:0]; end
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            OP_CPC, OP_SBC, OP_ADD, OP_CPSE, OP_CP, OP_SUB, OP_ADC,
            OP_AND, OP_EOR, OP_OR, OP_MOV:                        return "R2";
            OP_MOVW:                                              return "R3";
            OP_CPI, OP_SBCI, OP_SUBI, OP_ORI, OP_ANDI, OP_LDI:    return "R4";
            OP_ADIW, OP_SBIW:                                     return "R5";
            OP_COM, OP_NEG, OP_SWAP, OP_INC, OP_ASR, OP_LSR,
            OP_ROR, OP_DEC:                                       return "R6";
            OP_IN, OP_OUT:                                        return "R7";
            OP_BSET, OP_BCLR:                                     return "R8";
            OP_LDS, OP_STS:                                       return "R9";
            OP_JMP, OP_CALL:                                      return "R10";
            OP_RJMP, OP_RCALL:                                    return "R11";
            default:                                              return "R12";
        endcase
    endfunction

    task automatic step(input bit r, input bit v, input logic [15:0] w);
        string tag;
        exp_t  e;
        bit    two;
        @(negedge clk);
        rst = r; vld = v; wd = w;
        if (r) begin
            m_pend = 0; exp_done = 0; exp_rec = '0; tag = "R1";
        end else if (!v) begin
            exp_done = 0; tag = m_pend ? "R9" : "R13";
        end else if (m_pend) begin
            exp_rec = m_hold;
            exp_rec.far[15:0] = w;
            exp_done = 1; m_pend = 0;
            tag = tag_of(exp_rec.op);
        end else begin
            ref_dec(w, e, two);
            if (two) begin
                m_hold = e; m_pend = 1; exp_done = 0; tag = "R9";
            end else begin
                exp_rec = e; exp_done = 1; tag = tag_of(e.op);
            end
        end
        @(posedge clk);
        #1;
        total++;
        if (done !== exp_done || (exp_done && got !== exp_rec) || (r && got !== exp_rec)) begin
            bad++;
            $display("FAIL %s word=%h: got done=%0b rec=%h, expected done=%0b rec=%h",
                     tag, w, done, got, exp_done, exp_rec);
        end
    endtask

    logic [15:0] dir_words[] = '{
        16'h0D13, 16'h2F0F, 16'h0C00, 16'h1BFF, 16'h2400, 16'h0400, 16'h1000, 16'h0000,
        16'h01A5, 16'h01FF, 16'h0200, 16'h0312, 16'h00FF, 16'hE5AF, 16'h3F0F, 16'h4123,
        16'h5FFF, 16'h6000, 16'h7A5C, 16'h9500, 16'h95F1, 16'h9412, 16'h9583, 16'h95E5,
        16'h9406, 16'h9417, 16'h950A, 16'h9404, 16'h96FF, 16'h97C5, 16'h9600, 16'hB74F,
        16'hBF4F, 16'hB0FF, 16'hBE0F, 16'h9478, 16'h94F8, 16'h9408, 16'h9488, 16'h9508,
        16'h9598, 16'hC001, 16'hDFFF, 16'hC800, 16'hFFFF, 16'h8000, 16'hA123, 16'h9109
    };

    initial begin : watchdog
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL R13 watchdog expired: got no end, expected end of stimulus");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        step(1, 0, 16'h0);
        step(1, 1, 16'h0D13);
        // R2..R8, R11, R12 single-word groups
        foreach (dir_words[i]) step(0, 1, dir_words[i]);
        // R13: idle cycles between single words
        step(0, 0, 16'h0D13);
        step(0, 1, 16'h0D13);
        step(0, 0, 16'h0D13);
        // R9: LDS and STS with idle gaps before the address word
        step(0, 1, 16'h9100);
        step(0, 0, 16'h1234);
        step(0, 0, 16'h0D13);
        step(0, 1, 16'h0102);
        step(0, 1, 16'h9310);
        step(0, 1, 16'h9100);   // address word looking like LDS
        step(0, 1, 16'h93F0);
        step(0, 1, 16'hFFFF);
        // R10: JMP / CALL
        step(0, 1, 16'h940C);
        step(0, 1, 16'h940C);   // address word looking like JMP
        step(0, 1, 16'h95FF);
        step(0, 0, 16'h0);
        step(0, 1, 16'hBEEF);
        step(0, 1, 16'h941D);
        step(0, 1, 16'h0001);
        // R1: reset between the two halves drops the pending word
        step(0, 1, 16'h9310);
        step(1, 1, 16'h0102);
        step(0, 1, 16'h0D13);
        step(0, 1, 16'h940E);
        step(1, 0, 16'h0);
        step(0, 1, 16'h0109);
        // randomized mix with sparse valid and rare reset
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] w;
            bit v, r;
            w = 16'($urandom);
            if (($urandom % 4) == 0) w[15:9] = 7'b1001_010;
            v = ($urandom % 4) != 0;
            r = ($urandom % 250) == 0;
            step(r, v, w);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule